// File: doc/BRIEF.md
# Bit-Serial-Carry Phase Accumulator with Selectable Dither

This block produces the running phase of a numerically controlled oscillator at clock rates where a full-width carry chain would not close timing. The 32-bit accumulation is cut into single-bit cells, and each cell passes its carry to the next cell through a register, so the deepest logic path is one full adder. Bit `i` of a given sample is therefore produced `i` cycles after bit 0. A triangular delay line on the tuning word starts each cell in step with the carries arriving from below. A second triangular delay line on the kept upper bits realigns them so that every output word comes from a single sample.

The output is the upper 18 bits of the aligned sum. A 5-bit value from a 16-bit linear feedback shift register can be XORed into the five least significant bits of that output word to break up the spurs caused by truncation. The tuning word is a static setting. It is applied while reset is held, and the pipeline then refills before the output is flagged as valid. The sine lookup and any modulation stage sit downstream and are not part of this block.

Top module: `phase_acc_pipe`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next cycle shows `phase_o` equal to 0 and `valid_o` low.
- R2: `valid_o` first goes high after the 33rd rising edge that samples `rst_n` high, and it stays high until the next reset.
- R3: After rising edge n (counted from reset release, n ≥ 33), with dither off at that edge, `phase_o` equals bits [31:14] of ((n−32)·F) mod 2^32, where F is `ftw_i`. This gives one new sample per clock.
- R4: The accumulation wraps modulo 2^32 without a saturation or overflow indication. This holds for tuning words that set every bit and for words that set only bit 31.
- R5: When `dith_en_i` is low at an edge, the word produced by that edge is the undithered truncated phase on all 18 bits.
- R6: When `dith_en_i` is high at edge n, bits [4:0] of `phase_o` are XORed with bits [4:0] of the dither register as it stood before edge n, and bits [17:5] are unaffected. The dither register is 16 bits wide and is loaded with 0xACE1 by reset. Every clock it shifts left by one place, and its new bit 0 is the XOR of its old bits 15, 13, 12 and 10.
- R7: The dither enable is honoured edge by edge. Toggling it every cycle dithers exactly the outputs produced by edges where it was high, and the dither register advances whether the enable is high or low.
- R8: A reset asserted in the middle of operation, even for a single cycle, clears the output and restarts the fill of R2. The sample count then restarts at 1.
- R9: `ftw_i` must not change while `rst_n` is high. A new tuning word is taken up by holding reset while it changes and then releasing reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ftw_i | input | 32 | Frequency tuning word, static outside reset |
| dith_en_i | input | 1 | Applies LFSR dither to the output LSBs when high |
| phase_o | output | 18 | Aligned, truncated (optionally dithered) phase |
| valid_o | output | 1 | High once the pipeline has filled |

## Verification
The dither XOR and the carry-driven step of the phase both land on the low bits of the same output word in the same cycle. This matters most with tuning words such as 0xFFFFFFFF, where a carry ripples through every cell. The bench turns the enable on during the fill and toggles it on every cycle while wrap-around carries are present. It then judges each word against a behavioural model that multiplies the sample index by the tuning word and XORs in its own copy of the dither sequence. A separate checker requires the upper 13 bits to advance by the tuning step whatever the dither does.

// File: rtl/phacc_pkg.sv
// Package: shared constants for the pipelined phase accumulator.
// Assumes: nothing; pure constant definitions.
package phacc_pkg;
    localparam int unsigned DEF_ACC_W  = 32;
    localparam int unsigned DEF_OUT_W  = 18;
    localparam int unsigned DEF_DITH_W = 5;
    localparam int unsigned DEF_LFSR_W = 16;
    localparam logic [15:0] DEF_SEED   = 16'hACE1;
    // Feedback taps at bits 15, 13, 12 and 10 (maximal length, 16 bits).
    localparam logic [15:0] DEF_TAPS   = 16'hB400;
endpackage

// File: rtl/phacc_skew.sv
// Module: phacc_skew
// A single-bit delay line of DEPTH registers, cleared by reset.
// Assumes: DEPTH >= 1 (the caller wires a zero-delay bit directly).
module phacc_skew #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] sr;

    // Shift the bit one stage per clock; reset flushes to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= d;
            for (int k = 1; k < int'(DEPTH); k++) begin
                sr[k] <= sr[k-1];
            end
        end
    end

    assign q = sr[DEPTH-1];
endmodule

// File: rtl/phacc_chain.sv
// Module: phacc_chain
// Accumulator made of one-bit cells with a registered carry between cells.
// Bit i lags bit i-1 by one cycle; the tuning-word bit i is delayed by i
// cycles so that each cell starts adding exactly when its first carry lands.
// Assumes: ftw is static outside reset; ACC_W >= 2; OUT_W <= ACC_W.
module phacc_chain #(
    parameter int unsigned ACC_W = 32,
    parameter int unsigned OUT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw,
    output logic [OUT_W-1:0] top_skewed
);
    localparam int unsigned LOW = ACC_W - OUT_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] f_dly;
    logic [ACC_W-2:0] carry;

    for (genvar i = 0; i < int'(ACC_W); i++) begin : g_cell
        logic cin;

        // Input skew: bit i of the tuning word enters i cycles late.
        if (i == 0) begin : g_nodly
            assign f_dly[i] = ftw[i];
            assign cin      = 1'b0;
        end else begin : g_dly
            phacc_skew #(.DEPTH(i)) u_fskew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (ftw[i]),
                .q     (f_dly[i])
            );
            assign cin = carry[i-1];
        end

        if (i < int'(ACC_W) - 1) begin : g_full
            // One-bit add with registered carry out to the next cell.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    acc[i]   <= 1'b0;
                    carry[i] <= 1'b0;
                end else begin
                    {carry[i], acc[i]} <= 2'(acc[i]) + 2'(f_dly[i]) + 2'(cin);
                end
            end
        end else begin : g_msb
            // Top cell: the carry out is discarded (modulo 2^ACC_W).
            always_ff @(posedge clk) begin
                if (!rst_n) acc[i] <= 1'b0;
                else        acc[i] <= acc[i] ^ f_dly[i] ^ cin;
            end
        end
    end

    assign top_skewed = acc[ACC_W-1:LOW];
endmodule

// File: rtl/phacc_dither.sv
// Module: phacc_dither
// Fibonacci LFSR advancing every clock; its low bits form the dither value.
// Assumes: SEED is nonzero; TAPS describe a maximal-length polynomial.
module phacc_dither #(
    parameter int unsigned     LFSR_W = 16,
    parameter int unsigned     DITH_W = 5,
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DITH_W-1:0] dith
);
    logic [LFSR_W-1:0] state;
    logic              fb;

    // Feedback is the parity of the tapped bits.
    always_comb fb = ^(state & TAPS);

    // Shift left once per clock, feeding the parity into bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SEED;
        else        state <= {state[LFSR_W-2:0], fb};
    end

    assign dith = state[DITH_W-1:0];
endmodule

// File: rtl/phase_acc_pipe.sv
// Module: phase_acc_pipe (top)
// Carry-pipelined phase accumulator with output deskew, optional LFSR
// dither on the output LSBs and a fill-complete valid flag.
// Assumes: ftw_i only changes while rst_n is low; dith_en_i is synchronous.
module phase_acc_pipe
    import phacc_pkg::*;
#(
    parameter int unsigned       ACC_W  = DEF_ACC_W,
    parameter int unsigned       OUT_W  = DEF_OUT_W,
    parameter int unsigned       DITH_W = DEF_DITH_W,
    parameter int unsigned       LFSR_W = DEF_LFSR_W,
    parameter logic [LFSR_W-1:0] SEED   = DEF_SEED,
    parameter logic [LFSR_W-1:0] TAPS   = DEF_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] ftw_i,
    input  logic             dith_en_i,
    output logic [OUT_W-1:0] phase_o,
    output logic             valid_o
);
    localparam int unsigned LAT   = ACC_W + 1;
    localparam int unsigned CNT_W = $clog2(LAT + 1);
    localparam int unsigned LOW   = ACC_W - OUT_W;

    logic [OUT_W-1:0]  top_skewed;
    logic [OUT_W-1:0]  top_aligned;
    logic [DITH_W-1:0] dith;
    logic [OUT_W-1:0]  dith_mask;
    logic [CNT_W-1:0]  fill_cnt;

    phacc_chain #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .ftw        (ftw_i),
        .top_skewed (top_skewed)
    );

    // Output deskew: kept bit j (accumulator bit LOW+j) waits ACC_W-1-(LOW+j).
    for (genvar j = 0; j < int'(OUT_W); j++) begin : g_oskew
        if (j == int'(OUT_W) - 1) begin : g_nodly
            assign top_aligned[j] = top_skewed[j];
        end else begin : g_dly
            phacc_skew #(.DEPTH(ACC_W - 1 - LOW - j)) u_oskew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (top_skewed[j]),
                .q     (top_aligned[j])
            );
        end
    end

    phacc_dither #(
        .LFSR_W (LFSR_W),
        .DITH_W (DITH_W),
        .SEED   (SEED),
        .TAPS   (TAPS)
    ) u_dither (
        .clk   (clk),
        .rst_n (rst_n),
        .dith  (dith)
    );

    // Dither mask: LFSR bits in the output LSBs when enabled, else zero.
    always_comb dith_mask = dith_en_i ? OUT_W'(dith) : '0;

    // Output register: aligned word combined with the dither mask.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= '0;
        else        phase_o <= top_aligned ^ dith_mask;
    end

    // Fill counter: saturates one below the latency, then valid sticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            valid_o  <= 1'b0;
        end else begin
            if (fill_cnt != CNT_W'(LAT - 1)) fill_cnt <= fill_cnt + 1'b1;
            if (fill_cnt == CNT_W'(LAT - 1)) valid_o  <= 1'b1;
        end
    end
endmodule

// File: rtl/phase_acc_pipe_chk.sv
// Module: phase_acc_pipe_chk
// Port-level checker bound to phase_acc_pipe.
// Assumes: same parameter values as the bound instance.
module phase_acc_pipe_chk #(
    parameter int unsigned ACC_W  = 32,
    parameter int unsigned OUT_W  = 18,
    parameter int unsigned DITH_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] ftw_i,
    input logic             dith_en_i,
    input logic [OUT_W-1:0] phase_o,
    input logic             valid_o
);
    localparam int unsigned LAT = ACC_W + 1;
    localparam int unsigned HI  = OUT_W - DITH_W;

    logic [7:0]       edges;
    logic [OUT_W-1:0] stp;
    logic [HI-1:0]    stp_hi;

    assign stp    = ftw_i[ACC_W-1 -: OUT_W];
    assign stp_hi = ftw_i[ACC_W-1 -: HI];

    // Count edges since reset release, saturating well past the fill.
    always_ff @(posedge clk) begin
        if (!rst_n)                   edges <= '0;
        else if (edges != 8'd255)     edges <= edges + 8'd1;
    end

    // R1: reset clears output and valid.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && phase_o == '0));

    // R2: valid rises exactly when the fill completes.
    p_fill_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (32'(edges) >= LAT));

    // R2: valid stays high once set.
    p_valid_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    // R3: undithered consecutive words advance by the truncated step or one more.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o) && !$past(dith_en_i) && !$past(dith_en_i, 2))
        |-> (OUT_W'(phase_o - $past(phase_o)) == stp ||
             OUT_W'(phase_o - $past(phase_o)) == OUT_W'(stp + 1'b1)));

    // R6: dither never disturbs the bits above the dithered LSBs.
    p_upper_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && $past(valid_o))
        |-> (HI'(phase_o[OUT_W-1:DITH_W] - $past(phase_o[OUT_W-1:DITH_W])) == stp_hi ||
             HI'(phase_o[OUT_W-1:DITH_W] - $past(phase_o[OUT_W-1:DITH_W])) == HI'(stp_hi + 1'b1)));

    // R9: tuning word holds while out of reset.
    p_ftw_static_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(ftw_i));
endmodule

bind phase_acc_pipe phase_acc_pipe_chk #(
    .ACC_W  (ACC_W),
    .OUT_W  (OUT_W),
    .DITH_W (DITH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ftw_i     (ftw_i),
    .dith_en_i (dith_en_i),
    .phase_o   (phase_o),
    .valid_o   (valid_o)
);

// File: tb/sim_phase_acc_pipe.sv
// Bench: behavioural reference (multiply sample index by the tuning word,
// software LFSR) compared against the design after every clock.
module sim_phase_acc_pipe;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ftw = 32'h0;
    logic        den = 1'b0;
    logic [17:0] phase;
    logic        valid;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // model state
    longint n = 0;
    logic [15:0] lf = 16'hACE1;
    logic [17:0] exp_phase = '0;
    logic        exp_valid = 1'b0;

    always #10 clk = ~clk;

    phase_acc_pipe u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ftw_i     (ftw),
        .dith_en_i (den),
        .phase_o   (phase),
        .valid_o   (valid)
    );

    function automatic logic [15:0] lf_step(input logic [15:0] s);
        logic fb;
        fb = s[15] ^ s[13] ^ s[12] ^ s[10];
        return {s[14:0], fb};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h (n=%0d)", tag, act, expv, n);
        end
    endtask

    // One clock: model the edge from the inputs held across it, then compare.
    task automatic tick();
        logic        rb, eb;
        logic [15:0] lb;
        longint      k;
        logic [31:0] prod;
        rb = rst_n; eb = den; lb = lf;
        @(posedge clk);
        @(negedge clk);
        if (!rb) begin
            n = 0; lf = 16'hACE1;
            exp_phase = '0; exp_valid = 1'b0;
            check("R1 phase", 32'(phase), 32'(exp_phase));
            check("R1 valid", 32'(valid), 32'(exp_valid));
        end else begin
            n++;
            exp_valid = (n >= 33);
            k = n - 32;
            prod = 32'(k * longint'(ftw));
            exp_phase = prod[31:14] ^ (eb ? {13'b0, lb[4:0]} : 18'b0);
            lf = lf_step(lf);
            check("R2 valid", 32'(valid), 32'(exp_valid));
            if (exp_valid)
                check(eb ? "R6 dithered phase" : "R3 phase", 32'(phase), 32'(exp_phase));
        end
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) tick();
    endtask

    // R9: a new tuning word is applied only under reset.
    task automatic load(input logic [31:0] f);
        rst_n = 1'b0;
        tick();
        ftw = f;
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state
        ftw = 32'h1234_5678;
        run(3);
        rst_n = 1'b1;
        // R2, R3: fill then plain accumulation
        run(200);
        // R6: dither on
        den = 1'b1;
        run(100);
        // R7: enable toggled every cycle
        for (int i = 0; i < 40; i++) begin
            den = ~den;
            tick();
        end
        // R5: dither off again
        den = 1'b0;
        run(50);

        // R4, R9: all-ones word, dither on during the fill
        load(32'hFFFF_FFFF);
        den = 1'b1;
        run(100);
        for (int i = 0; i < 60; i++) begin
            den = ~den;
            tick();
        end
        den = 1'b0;

        // R4: only bit 31 set
        load(32'h8000_0000);
        run(100);

        // R4: many wraps of an irregular word
        load(32'h9E37_79B9);
        run(3000);

        // R8: single-cycle reset in mid-run, then refill
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        run(80);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule